// File: doc/BRIEF.md
# Multichannel Parallel Output Formatter

This block collects the finished results of four receive channels, each of which delivers an in-phase sample, a quadrature sample and a gain word, and places them one at a time onto a 16-bit output bus. A host sets the order of the words by writing a small sequence table through a register write port. The same port sets the number of table entries in use, an option that inverts every output bit, and a mode that splits the bus into two byte lanes, each with its own half of the table.

Each pulse of the output clock enable moves the block to the next table entry and registers the selected word onto the bus. A valid strobe marks each new word, and a start marker flags the word taken from entry 0. When a channel asserts its strobe, its three words are captured into a holding register. An interrupt flag goes high once every channel named by the active part of the table has delivered a new set. It goes low when the last entry of the sequence is sent, so a host can read the bus in bursts, much as it would read a FIFO.

Top module: `seq_out_formatter`

## Requirements
- R1: While `rst` is high at a clock edge, `dout` becomes 0, `dout_valid`, `sos` and `irq` become 0, the sequence position returns to entry 0, all table entries and holding registers become 0, and the control register becomes 0 (length of one entry, no inversion, no split).
- R2: A table entry is 4 bits. Bits [1:0] give the channel number and bits [3:2] give the item: 00 selects the in-phase sample, 01 the quadrature sample, 10 the gain word. The code 11 selects an all-zero word, and inversion is applied to it afterwards.
- R3: Each clock edge that samples `out_en` high registers the word of the current entry onto `dout` and moves to the next entry. After the entry whose index is equal to or greater than the last-index field (control bits [3:0]), the position wraps to entry 0.
- R4: A clock edge that samples `out_en` low leaves `dout` unchanged and drives `dout_valid` low for the next cycle.
- R5: `dout_valid` is high for exactly the cycle after each sampled `out_en`. `sos` is high in that same cycle when the word came from position 0.
- R6: When control bit 4 is set, every bit of the output word is inverted. The inversion is applied after item selection and after lane slicing.
- R7: When control bit 5 is set, `dout[15:8]` takes the upper byte of the item at position p, and `dout[7:0]` takes the upper byte of the item at position p+8. The position wraps after control bits [2:0], so each lane uses only its own half of the table.
- R8: A channel strobe captures that channel's three input words at the clock edge. If `out_en` is sampled at the same edge, the word sent comes from the contents held before that capture.
- R9: `irq` rises at the clock edge where, counting the strobes sampled at that edge, every channel referenced by an active table entry has a new set since the last end of sequence. Entries with item code 11 reference no channel, and a table that references no channel never raises `irq`.
- R10: The edge that sends the last active entry clears `irq` and clears every channel's new-data mark, except for channels that strobe at the same edge. The clear of `irq` takes priority over a set at the same edge.
- R11: A write to address 16 loads the control register. Writes to addresses 0 to 15 load table entries. Writes to addresses 17 to 31 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address: 0-15 table, 16 control |
| cfg_wdata | input | 6 | Write data: an entry in [3:0], or control (last index [3:0], invert [4], split [5]) |
| smp_stb | input | 4 | One new-sample strobe per channel |
| smp_i | input | 64 | In-phase samples, channel c at [16c+15:16c] |
| smp_q | input | 64 | Quadrature samples, same packing |
| smp_gain | input | 64 | Gain words, same packing |
| out_en | input | 1 | Output clock enable; advances the sequence |
| dout | output | 16 | Formatted output word |
| dout_valid | output | 1 | A new word is on `dout` |
| sos | output | 1 | The current word came from sequence position 0 |
| irq | output | 1 | Data-ready flag for burst reads |

## Verification
On every cycle, the assertions check the reset values, that the output holds and the valid strobe stays low when no enable is sampled, that a valid strobe follows each enable, that the start marker never appears without a valid word, and that the interrupt is low right after the final entry is sent. Only the bench scenarios can show which word appears on the bus. That covers the entry ordering and wrap, the reserved item code, inversion, split-lane slicing, the effect of a capture that coincides with an enable, writes to unused addresses, and the exact edge at which the interrupt rises. The bench checks these against a cycle-level reference model.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    localparam int FMT_DW   = 16;
    localparam int FMT_CH_W = 2;

    typedef enum logic [1:0] {
        KIND_I    = 2'b00,
        KIND_Q    = 2'b01,
        KIND_GAIN = 2'b10,
        KIND_NONE = 2'b11
    } item_kind_e;

    typedef struct packed {
        item_kind_e            kind;
        logic [FMT_CH_W-1:0]   chan;
    } seq_entry_t;

    typedef struct packed {
        logic [FMT_DW-1:0] gain;
        logic [FMT_DW-1:0] q;
        logic [FMT_DW-1:0] i;
    } chan_set_t;

    function automatic logic [FMT_DW-1:0] pick_item(chan_set_t s, item_kind_e k);
        case (k)
            KIND_I:    return s.i;
            KIND_Q:    return s.q;
            KIND_GAIN: return s.gain;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/fmt_cfg_regs.sv
module fmt_cfg_regs
    import fmt_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int SEQ_DEPTH = 16,
    parameter int IDX_W     = $clog2(SEQ_DEPTH),
    parameter int ADDR_W    = IDX_W + 1,
    parameter int CFG_W     = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output seq_entry_t         tbl [SEQ_DEPTH],
    output logic [IDX_W-1:0]   eff_last,
    output logic               inv_en,
    output logic               split_en,
    output logic [NUM_CH-1:0]  ref_mask
);
    localparam int HALF = SEQ_DEPTH / 2;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(SEQ_DEPTH);

    seq_entry_t       tbl_q [SEQ_DEPTH];
    logic [IDX_W-1:0] last_q;
    logic             inv_q;
    logic             split_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < SEQ_DEPTH; k++) tbl_q[k] <= '0;
            last_q  <= '0;
            inv_q   <= 1'b0;
            split_q <= 1'b0;
        end else if (cfg_we) begin
            if (!cfg_addr[ADDR_W-1]) begin
                tbl_q[cfg_addr[IDX_W-1:0]] <= seq_entry_t'(cfg_wdata[3:0]);
            end else if (cfg_addr == CTRL_ADDR) begin
                last_q  <= cfg_wdata[IDX_W-1:0];
                inv_q   <= cfg_wdata[IDX_W];
                split_q <= cfg_wdata[IDX_W+1];
            end
        end
    end

    assign tbl      = tbl_q;
    assign inv_en   = inv_q;
    assign split_en = split_q;
    assign eff_last = split_q ? (last_q & IDX_W'(HALF - 1)) : last_q;

    // Channels named by the active part of the table
    always_comb begin
        logic [IDX_W-1:0] pos;
        logic [IDX_W-1:0] key;
        ref_mask = '0;
        for (int k = 0; k < SEQ_DEPTH; k++) begin
            pos = IDX_W'(k);
            key = split_q ? (pos & IDX_W'(HALF - 1)) : pos;
            if (key <= eff_last && tbl_q[k].kind != KIND_NONE)
                ref_mask[tbl_q[k].chan] = 1'b1;
        end
    end

endmodule

// File: rtl/fmt_sample_hold.sv
module fmt_sample_hold
    import fmt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DW     = FMT_DW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CH-1:0]    smp_stb,
    input  logic [NUM_CH*DW-1:0] smp_i,
    input  logic [NUM_CH*DW-1:0] smp_q,
    input  logic [NUM_CH*DW-1:0] smp_gain,
    input  logic                 seq_end,
    output chan_set_t            held [NUM_CH],
    output logic [NUM_CH-1:0]    fresh_nxt
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_set_t h_q;
        logic      f_q;
        logic      f_d;

        assign f_d = smp_stb[c] | (f_q & ~seq_end);

        always_ff @(posedge clk) begin
            if (rst) begin
                h_q <= '0;
                f_q <= 1'b0;
            end else begin
                f_q <= f_d;
                if (smp_stb[c]) begin
                    h_q.i    <= smp_i[c*DW +: DW];
                    h_q.q    <= smp_q[c*DW +: DW];
                    h_q.gain <= smp_gain[c*DW +: DW];
                end
            end
        end

        assign held[c]      = h_q;
        assign fresh_nxt[c] = f_d;
    end

endmodule

// File: rtl/fmt_sequencer.sv
module fmt_sequencer #(
    parameter int SEQ_DEPTH = 16,
    parameter int IDX_W     = $clog2(SEQ_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [IDX_W-1:0] eff_last,
    output logic [IDX_W-1:0] idx,
    output logic             at_start,
    output logic             seq_end
);
    logic [IDX_W-1:0] idx_q;
    logic             wrap;

    assign wrap     = idx_q >= eff_last;
    assign seq_end  = adv && wrap;
    assign at_start = idx_q == '0;
    assign idx      = idx_q;

    always_ff @(posedge clk) begin
        if (rst)      idx_q <= '0;
        else if (adv) idx_q <= wrap ? '0 : idx_q + 1'b1;
    end

endmodule

// File: rtl/seq_out_formatter.sv
module seq_out_formatter
    import fmt_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int SEQ_DEPTH = 16,
    parameter int DW        = FMT_DW,
    parameter int IDX_W     = $clog2(SEQ_DEPTH),
    parameter int ADDR_W    = IDX_W + 1,
    parameter int CFG_W     = IDX_W + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic [NUM_CH-1:0]    smp_stb,
    input  logic [NUM_CH*DW-1:0] smp_i,
    input  logic [NUM_CH*DW-1:0] smp_q,
    input  logic [NUM_CH*DW-1:0] smp_gain,
    input  logic                 out_en,
    output logic [DW-1:0]        dout,
    output logic                 dout_valid,
    output logic                 sos,
    output logic                 irq
);
    localparam int HALF   = SEQ_DEPTH / 2;
    localparam int LANE_W = DW / 2;

    seq_entry_t        tbl [SEQ_DEPTH];
    logic [IDX_W-1:0]  eff_last;
    logic              inv_en;
    logic              split_en;
    logic [NUM_CH-1:0] ref_mask;
    chan_set_t         held [NUM_CH];
    logic [NUM_CH-1:0] fresh_nxt;
    logic [IDX_W-1:0]  idx;
    logic              at_start;
    logic              seq_end;

    fmt_cfg_regs #(
        .NUM_CH(NUM_CH), .SEQ_DEPTH(SEQ_DEPTH), .IDX_W(IDX_W),
        .ADDR_W(ADDR_W), .CFG_W(CFG_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tbl(tbl), .eff_last(eff_last),
        .inv_en(inv_en), .split_en(split_en), .ref_mask(ref_mask)
    );

    fmt_sample_hold #(.NUM_CH(NUM_CH), .DW(DW)) u_hold (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_i(smp_i),
        .smp_q(smp_q), .smp_gain(smp_gain), .seq_end(seq_end),
        .held(held), .fresh_nxt(fresh_nxt)
    );

    fmt_sequencer #(.SEQ_DEPTH(SEQ_DEPTH), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst(rst), .adv(out_en), .eff_last(eff_last),
        .idx(idx), .at_start(at_start), .seq_end(seq_end)
    );

    // Item selection for both lanes
    seq_entry_t       ent_a;
    seq_entry_t       ent_b;
    logic [IDX_W-1:0] idx_b;
    logic [DW-1:0]    word_a;
    logic [DW-1:0]    word_b;
    logic [DW-1:0]    word;

    assign idx_b  = idx + IDX_W'(HALF);
    assign ent_a  = tbl[idx];
    assign ent_b  = tbl[idx_b];
    assign word_a = pick_item(held[ent_a.chan], ent_a.kind);
    assign word_b = pick_item(held[ent_b.chan], ent_b.kind);

    // Slice first, then invert
    always_comb begin
        if (split_en) word = {word_a[DW-1 -: LANE_W], word_b[DW-1 -: LANE_W]};
        else          word = word_a;
        if (inv_en)   word = ~word;
    end

    logic [DW-1:0] dout_q;
    logic          valid_q;
    logic          sos_q;
    logic          irq_q;
    logic          all_fresh;

    assign all_fresh = (ref_mask != '0) && ((fresh_nxt & ref_mask) == ref_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q  <= '0;
            valid_q <= 1'b0;
            sos_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            valid_q <= out_en;
            sos_q   <= out_en && at_start;
            if (out_en)         dout_q <= word;
            if (seq_end)        irq_q  <= 1'b0;
            else if (all_fresh) irq_q  <= 1'b1;
        end
    end

    assign dout       = dout_q;
    assign dout_valid = valid_q;
    assign sos        = sos_q;
    assign irq        = irq_q;

endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          out_en,
    input logic [DW-1:0] dout,
    input logic          dout_valid,
    input logic          sos,
    input logic          irq,
    input logic          seq_end
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (dout == '0 && !dout_valid && !sos && !irq));

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> ($stable(dout) && !dout_valid));

    p_valid_after_en_r5: assert property (@(posedge clk) disable iff (rst)
        out_en |=> dout_valid);

    p_sos_with_valid_r5: assert property (@(posedge clk) disable iff (rst)
        sos |-> dout_valid);

    p_irq_drop_r10: assert property (@(posedge clk) disable iff (rst)
        seq_end |=> !irq);

endmodule

bind seq_out_formatter fmt_checker #(.DW(DW)) u_fmt_checker (
    .clk(clk), .rst(rst), .out_en(out_en), .dout(dout),
    .dout_valid(dout_valid), .sos(sos), .irq(irq), .seq_end(seq_end)
);

// File: tb/test_seq_out_formatter.sv
module test_seq_out_formatter;

    localparam int NCH = 4;
    localparam int DW  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_addr = '0;
    logic [5:0]    cfg_wdata = '0;
    logic [3:0]    smp_stb = '0;
    logic [63:0]   smp_i = '0, smp_q = '0, smp_gain = '0;
    logic          out_en = 1'b0;
    logic [15:0]   dout;
    logic          dout_valid, sos, irq;

    always #2 clk = ~clk;

    seq_out_formatter i_seq_out_formatter (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .smp_stb(smp_stb), .smp_i(smp_i),
        .smp_q(smp_q), .smp_gain(smp_gain), .out_en(out_en),
        .dout(dout), .dout_valid(dout_valid), .sos(sos), .irq(irq)
    );

    // Reference model state
    logic [3:0]  m_tbl [16];
    logic [3:0]  m_last;
    logic        m_inv, m_split;
    logic [15:0] m_i [NCH];
    logic [15:0] m_q [NCH];
    logic [15:0] m_g [NCH];
    logic [3:0]  m_fresh, m_idx;
    logic [15:0] m_dout;
    logic        m_valid, m_sos, m_irq;

    int    n_cmp = 0, n_bad = 0;
    string tag = "R1";

    function automatic logic [15:0] item_of(logic [3:0] e);
        case (e[3:2])
            2'b00:   return m_i[e[1:0]];
            2'b01:   return m_q[e[1:0]];
            2'b10:   return m_g[e[1:0]];
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_clock();
        logic [3:0]  eff, ib, refm, fn;
        logic        endv;
        logic [15:0] wa, wb, w;
        if (rst) begin
            for (int k = 0; k < 16; k++) m_tbl[k] = '0;
            for (int c = 0; c < NCH; c++) begin m_i[c] = '0; m_q[c] = '0; m_g[c] = '0; end
            m_last = '0; m_inv = 0; m_split = 0; m_fresh = '0; m_idx = '0;
            m_dout = '0; m_valid = 0; m_sos = 0; m_irq = 0;
            return;
        end
        eff  = m_split ? {1'b0, m_last[2:0]} : m_last;
        endv = out_en && (m_idx >= eff);
        refm = '0;
        for (int k = 0; k < 16; k++) begin
            logic [3:0] key;
            key = m_split ? (4'(k) & 4'd7) : 4'(k);
            if (key <= eff && m_tbl[k][3:2] != 2'b11) refm[m_tbl[k][1:0]] = 1'b1;
        end
        fn = smp_stb | (m_fresh & {4{~endv}});
        if (out_en) begin
            wa = item_of(m_tbl[m_idx]);
            ib = m_idx + 4'd8;
            wb = item_of(m_tbl[ib]);
            w  = m_split ? {wa[15:8], wb[15:8]} : wa;
            if (m_inv) w = ~w;
            m_dout = w;
        end
        m_valid = out_en;
        m_sos   = out_en && (m_idx == 4'd0);
        if (out_en) m_idx = endv ? 4'd0 : m_idx + 4'd1;
        if (endv) m_irq = 1'b0;
        else if (refm != 0 && (fn & refm) == refm) m_irq = 1'b1;
        m_fresh = fn;
        for (int c = 0; c < NCH; c++) if (smp_stb[c]) begin
            m_i[c] = smp_i[c*DW +: DW];
            m_q[c] = smp_q[c*DW +: DW];
            m_g[c] = smp_gain[c*DW +: DW];
        end
        if (cfg_we) begin
            if (!cfg_addr[4]) m_tbl[cfg_addr[3:0]] = cfg_wdata[3:0];
            else if (cfg_addr == 5'd16) begin
                m_last = cfg_wdata[3:0]; m_inv = cfg_wdata[4]; m_split = cfg_wdata[5];
            end
        end
    endtask

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(tag, "dout", 32'(dout), 32'(m_dout));
        chk("R5", "dout_valid", 32'(dout_valid), 32'(m_valid));
        chk("R5", "sos", 32'(sos), 32'(m_sos));
        chk("R9 R10", "irq", 32'(irq), 32'(m_irq));
    endtask

    task automatic tick();
        @(posedge clk);
        model_clock();
        @(negedge clk);
        compare();
        cfg_we  = 1'b0;
        smp_stb = '0;
        out_en  = 1'b0;
    endtask

    task automatic wr(logic [4:0] a, logic [5:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
    endtask

    task automatic load_all();
        smp_i = {$urandom, $urandom}; smp_q = {$urandom, $urandom};
        smp_gain = {$urandom, $urandom};
        smp_stb = 4'hF;
        tick();
    endtask

    task automatic run(int n, bit gaps);
        for (int k = 0; k < n; k++) begin
            out_en = gaps ? 1'($urandom % 2) : 1'b1;
            tick();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        tag = "R1";
        tick(); tick();
        rst = 1'b0;
        tick();
        // R11: table and control writes
        tag = "R11";
        wr(5'd0, 6'h00); wr(5'd1, 6'h05); wr(5'd2, 6'h0A); wr(5'd3, 6'h03);
        wr(5'd4, 6'h0C);
        for (int k = 5; k < 16; k++) wr(5'(k), 6'($urandom % 16));
        wr(5'd16, 6'h03);
        // R8: capture from all channels, then R3 ordered sequence with wrap
        tag = "R8";
        load_all();
        tag = "R3";
        run(10, 0);
        // R4: gaps in the enable hold the output
        tag = "R4";
        load_all();
        run(24, 1);
        // R2: reserved item code gives zero
        tag = "R2";
        wr(5'd16, 6'h04);
        load_all();
        run(12, 0);
        // R6: inversion
        tag = "R6";
        wr(5'd16, 6'h14);
        load_all();
        run(12, 1);
        // R7: split lanes, plain then inverted
        tag = "R7";
        wr(5'd8, 6'h09); wr(5'd9, 6'h02); wr(5'd10, 6'h07);
        wr(5'd16, 6'h22);
        load_all();
        run(9, 0);
        wr(5'd16, 6'h3A);
        load_all();
        run(9, 1);
        // R11: writes to unused addresses change nothing
        tag = "R11";
        for (int a = 17; a < 32; a++) wr(5'(a), 6'($urandom));
        load_all();
        run(9, 0);
        // R8: strobe coinciding with enable sends the old word
        tag = "R8";
        wr(5'd16, 6'h01);
        for (int k = 0; k < 6; k++) begin
            smp_i = {$urandom, $urandom}; smp_stb = 4'hF; out_en = 1'b1;
            tick();
        end
        // R10: end of sequence together with a completing strobe
        tag = "R10";
        wr(5'd16, 6'h03);
        load_all();
        smp_stb = 4'hF; out_en = 1'b1;
        run(8, 0);
        // R9: partial strobes raise the flag only once all are fresh
        tag = "R9";
        for (int c = 0; c < NCH; c++) begin smp_stb = 4'(1 << c); tick(); end
        run(6, 1);
        // Random mix
        tag = "R3";
        for (int k = 0; k < 4000; k++) begin
            out_en   = ($urandom % 4) != 0;
            smp_stb  = 4'($urandom) & 4'($urandom);
            smp_i    = {$urandom, $urandom};
            smp_q    = {$urandom, $urandom};
            smp_gain = {$urandom, $urandom};
            if ($urandom % 24 == 0) begin
                cfg_we = 1'b1; cfg_addr = 5'($urandom); cfg_wdata = 6'($urandom);
                if ($urandom % 3 == 0) cfg_addr = 5'd16;
            end
            tick();
        end
        // R1: reset in the middle of operation
        tag = "R1";
        rst = 1'b1;
        out_en = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule